// File: doc/BRIEF.md
# Translation Table Region Selector

This block decides which of two translation-table regions is responsible for a 64-bit input address. Each region carries a size field, a disable flag, a granule code and a table base. A size field of N puts the region in charge of the addresses whose upper N bits are all zeros (region 0) or all ones (region 1). Two top-byte-ignore flags can remove the upper address byte from that range check, and address bit 55 chooses which of the two flags applies.

A region whose size field is zero takes every address that the other region does not claim. An address that neither sized region claims falls in the gap between them and is reported as a translation fault. A fault is also reported when the chosen region is disabled.

A request is a single strobe with the address and configuration. One cycle later the block returns a registered response: a one-hot region select or a fault flag, and the size, granule and base of the chosen region. A page-table walker can use these fields directly.

Top module: `tt_region_sel`

## Requirements
- R1: Address bit 55 chooses the top-byte-ignore flag: `tbi1_i` is used when the bit is 1 and `tbi0_i` when it is 0. The other flag has no effect.
- R2: When the chosen ignore flag is 1, address bits 63:56 are left out of the range check. If a region's size is 8 or less, its checked range is then empty and counts as matched.
- R3: Region 0 is chosen (`sel_o` = 2'b01) when `r0_tsz_i` is nonzero and address bits [63 : 64-r0_tsz_i] that are still checked are all zero.
- R4: If R3 does not apply, region 1 is chosen (`sel_o` = 2'b10) when `r1_tsz_i` is nonzero and address bits [63 : 64-r1_tsz_i] that are still checked are all one.
- R5: If neither R3 nor R4 applies and `r0_tsz_i` is zero, region 0 is chosen.
- R6: If R3, R4 and R5 do not apply and `r1_tsz_i` is zero, region 1 is chosen.
- R7: An address claimed by neither region while both sizes are nonzero gives `fault_o` = 1 and `sel_o` = 2'b00.
- R8: If the chosen region has its disable flag set, the response is a fault (`fault_o` = 1, `sel_o` = 2'b00).
- R9: `rsp_vld_o` is `req_vld_i` delayed by one clock. When it is high, exactly one of `sel_o[0]`, `sel_o[1]` and `fault_o` is 1.
- R10: On a non-fault response, `tsz_o`, `gran_o` and `base_o` carry the chosen region's fields. On a fault response they are zero.
- R11: While `req_vld_i` is low, the result outputs keep their previous values.
- R12: After reset, `rsp_vld_o`, `sel_o`, `fault_o`, `tsz_o`, `gran_o` and `base_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Request strobe |
| addr_i | input | 64 | Input address |
| tbi0_i | input | 1 | Top-byte-ignore flag used when address bit 55 is 0 |
| tbi1_i | input | 1 | Top-byte-ignore flag used when address bit 55 is 1 |
| r0_tsz_i | input | 6 | Region 0 size field |
| r0_dis_i | input | 1 | Region 0 disable |
| r0_gran_i | input | 2 | Region 0 granule code |
| r0_base_i | input | 48 | Region 0 table base |
| r1_tsz_i | input | 6 | Region 1 size field |
| r1_dis_i | input | 1 | Region 1 disable |
| r1_gran_i | input | 2 | Region 1 granule code |
| r1_base_i | input | 48 | Region 1 table base |
| rsp_vld_o | output | 1 | Response valid, one cycle after the request |
| sel_o | output | 2 | One-hot region select, 2'b01 for region 0 and 2'b10 for region 1 |
| fault_o | output | 1 | Translation fault |
| tsz_o | output | 6 | Size field of the chosen region |
| gran_o | output | 2 | Granule code of the chosen region |
| base_o | output | 48 | Table base of the chosen region |

## Verification
Most internal faults become visible on the response that follows the offending request, one cycle after the strobe:
- A wrong checked-bit mask shows as a wrong region or a spurious fault, most clearly for addresses next to the ignored byte and for very small or very large sizes.
- A broken priority chain shows when both regions or a zero-size default could claim the same address.
- A stale response register shows during idle cycles as outputs that change when they should hold.

// File: rtl/tt_sel_pkg.sv
package tt_sel_pkg;
  localparam int ADDR_W      = 64;
  localparam int TSZ_W       = 6;
  localparam int GRAN_W      = 2;
  localparam int BASE_W      = 48;
  localparam int TBI_BITS    = 8;
  localparam int TBI_SEL_BIT = 55;
  localparam int NUM_RGN     = 2;

  typedef struct packed {
    logic [TSZ_W-1:0]  tsz;
    logic              dis;
    logic [GRAN_W-1:0] gran;
    logic [BASE_W-1:0] base;
  } rgn_cfg_t;
endpackage

// File: rtl/tt_range_mask.sv
module tt_range_mask #(
  parameter int ADDR_W   = tt_sel_pkg::ADDR_W,
  parameter int TSZ_W    = tt_sel_pkg::TSZ_W,
  parameter int TBI_BITS = tt_sel_pkg::TBI_BITS
) (
  input  logic [TSZ_W-1:0]  tsz_i,
  input  logic              tbi_i,
  output logic [ADDR_W-1:0] chk_mask_o
);
  localparam int TBI_LO = ADDR_W - TBI_BITS;

  // bit i is checked when it lies in the top tsz bits and is not an ignored top-byte bit
  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      chk_mask_o[i] = (i >= (ADDR_W - int'(tsz_i))) && !(tbi_i && (i >= TBI_LO));
    end
  end
endmodule

// File: rtl/tt_region_match.sv
module tt_region_match #(
  parameter int ADDR_W   = tt_sel_pkg::ADDR_W,
  parameter int TSZ_W    = tt_sel_pkg::TSZ_W,
  parameter int TBI_BITS = tt_sel_pkg::TBI_BITS,
  parameter bit ONES     = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TSZ_W-1:0]  tsz_i,
  input  logic              tbi_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] chk_mask;
  logic              pat_ok;

  tt_range_mask #(
    .ADDR_W  (ADDR_W),
    .TSZ_W   (TSZ_W),
    .TBI_BITS(TBI_BITS)
  ) u_mask (
    .tsz_i     (tsz_i),
    .tbi_i     (tbi_i),
    .chk_mask_o(chk_mask)
  );

  generate
    if (ONES) begin : g_ones
      assign pat_ok = &(addr_i | ~chk_mask);
    end else begin : g_zeros
      assign pat_ok = ~|(addr_i & chk_mask);
    end
  endgenerate

  assign hit_o = (tsz_i != '0) && pat_ok;
endmodule

// File: rtl/tt_sel_resolve.sv
module tt_sel_resolve
  import tt_sel_pkg::*;
(
  input  logic     hit0_i,
  input  logic     hit1_i,
  input  rgn_cfg_t cfg0_i,
  input  rgn_cfg_t cfg1_i,
  output logic [NUM_RGN-1:0] sel_o,
  output logic     fault_o,
  output rgn_cfg_t cfg_o
);
  logic     pick_any;
  logic     pick_one;
  rgn_cfg_t pick_cfg;

  // priority: sized match 0, sized match 1, default 0, default 1, else gap
  always_comb begin
    pick_any = 1'b1;
    pick_one = 1'b0;
    if (hit0_i)                   pick_one = 1'b0;
    else if (hit1_i)              pick_one = 1'b1;
    else if (cfg0_i.tsz == '0)    pick_one = 1'b0;
    else if (cfg1_i.tsz == '0)    pick_one = 1'b1;
    else                          pick_any = 1'b0;
  end

  assign pick_cfg = pick_one ? cfg1_i : cfg0_i;

  always_comb begin
    sel_o   = '0;
    fault_o = 1'b0;
    cfg_o   = '0;
    if (!pick_any || pick_cfg.dis) begin
      fault_o = 1'b1;
    end else begin
      sel_o[pick_one] = 1'b1;
      cfg_o           = pick_cfg;
      cfg_o.dis       = 1'b0;
    end
  end
endmodule

// File: rtl/tt_region_sel.sv
module tt_region_sel
  import tt_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tbi0_i,
  input  logic              tbi1_i,
  input  logic [TSZ_W-1:0]  r0_tsz_i,
  input  logic              r0_dis_i,
  input  logic [GRAN_W-1:0] r0_gran_i,
  input  logic [BASE_W-1:0] r0_base_i,
  input  logic [TSZ_W-1:0]  r1_tsz_i,
  input  logic              r1_dis_i,
  input  logic [GRAN_W-1:0] r1_gran_i,
  input  logic [BASE_W-1:0] r1_base_i,
  output logic              rsp_vld_o,
  output logic [NUM_RGN-1:0] sel_o,
  output logic              fault_o,
  output logic [TSZ_W-1:0]  tsz_o,
  output logic [GRAN_W-1:0] gran_o,
  output logic [BASE_W-1:0] base_o
);
  rgn_cfg_t           cfg [NUM_RGN];
  logic [NUM_RGN-1:0] hit;
  logic               tbi_eff;
  logic [NUM_RGN-1:0] sel_d;
  logic               fault_d;
  rgn_cfg_t           cfg_d;
  rgn_cfg_t           cfg_q;

  assign cfg[0]  = '{tsz: r0_tsz_i, dis: r0_dis_i, gran: r0_gran_i, base: r0_base_i};
  assign cfg[1]  = '{tsz: r1_tsz_i, dis: r1_dis_i, gran: r1_gran_i, base: r1_base_i};
  assign tbi_eff = addr_i[TBI_SEL_BIT] ? tbi1_i : tbi0_i;

  // region g matches on all-zero (g=0) or all-one (g=1) upper bits
  generate
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      tt_region_match #(
        .ADDR_W  (ADDR_W),
        .TSZ_W   (TSZ_W),
        .TBI_BITS(TBI_BITS),
        .ONES    (g == 1)
      ) u_match (
        .addr_i(addr_i),
        .tsz_i (cfg[g].tsz),
        .tbi_i (tbi_eff),
        .hit_o (hit[g])
      );
    end
  endgenerate

  tt_sel_resolve u_resolve (
    .hit0_i (hit[0]),
    .hit1_i (hit[1]),
    .cfg0_i (cfg[0]),
    .cfg1_i (cfg[1]),
    .sel_o  (sel_d),
    .fault_o(fault_d),
    .cfg_o  (cfg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o <= 1'b0;
      sel_o     <= '0;
      fault_o   <= 1'b0;
      cfg_q     <= '0;
    end else begin
      rsp_vld_o <= req_vld_i;
      if (req_vld_i) begin
        sel_o   <= sel_d;
        fault_o <= fault_d;
        cfg_q   <= cfg_d;
      end
    end
  end

  assign tsz_o  = cfg_q.tsz;
  assign gran_o = cfg_q.gran;
  assign base_o = cfg_q.base;
endmodule

// File: rtl/tt_region_sel_chk.sv
module tt_region_sel_chk
  import tt_sel_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_vld_i,
  input logic              r0_dis_i,
  input logic              r1_dis_i,
  input logic [TSZ_W-1:0]  r0_tsz_i,
  input logic [TSZ_W-1:0]  r1_tsz_i,
  input logic              rsp_vld_o,
  input logic [NUM_RGN-1:0] sel_o,
  input logic              fault_o,
  input logic [TSZ_W-1:0]  tsz_o,
  input logic [BASE_W-1:0] base_o
);
  AST_VLD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> rsp_vld_o); // R9
  AST_NO_SPUR_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> !rsp_vld_o); // R9
  AST_EXCL_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> $countones({sel_o, fault_o}) == 1); // R9
  AST_FAULT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && fault_o) |-> (tsz_o == '0 && base_o == '0)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> ($stable(sel_o) && $stable(fault_o) && $stable(base_o))); // R11
  AST_BOTH_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && r0_dis_i && r1_dis_i) |=> fault_o); // R8
  AST_ZERO_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && r0_tsz_i == '0 && r1_tsz_i == '0 && !r0_dis_i) |=> sel_o == 2'b01); // R5
endmodule

bind tt_region_sel tt_region_sel_chk u_chk (.*);

// File: tb/tt_region_sel_tb_top.sv
module tt_region_sel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_vld_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic        tbi0_i = 1'b0, tbi1_i = 1'b0;
  logic [5:0]  r0_tsz_i = '0, r1_tsz_i = '0;
  logic        r0_dis_i = 1'b0, r1_dis_i = 1'b0;
  logic [1:0]  r0_gran_i = '0, r1_gran_i = '0;
  logic [47:0] r0_base_i = '0, r1_base_i = '0;
  logic        rsp_vld_o;
  logic [1:0]  sel_o;
  logic        fault_o;
  logic [5:0]  tsz_o;
  logic [1:0]  gran_o;
  logic [47:0] base_o;

  always #4 clk_i = ~clk_i;

  tt_region_sel dut_i (.*);

  typedef struct packed {
    logic [1:0]  sel;
    logic        fault;
    logic [5:0]  tsz;
    logic [1:0]  gran;
    logic [47:0] base;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    have_last = 0;
  exp_t  last;

  function automatic bit rgn_hit(logic [63:0] a, logic [5:0] tsz, bit tbi, bit ones);
    int lo = 64 - int'(tsz);
    int hi = tbi ? 56 : 64;
    if (tsz == 0) return 0;
    for (int i = lo; i < hi; i++) if (a[i] != ones) return 0;
    return 1;
  endfunction

  function automatic exp_t model(logic [63:0] a);
    exp_t e = '0;
    bit tbi = a[55] ? tbi1_i : tbi0_i;
    int pick;
    if (rgn_hit(a, r0_tsz_i, tbi, 0))      pick = 0;
    else if (rgn_hit(a, r1_tsz_i, tbi, 1)) pick = 1;
    else if (r0_tsz_i == 0)                pick = 0;
    else if (r1_tsz_i == 0)                pick = 1;
    else                                   pick = -1;
    if (pick == 0 && !r0_dis_i) begin
      e.sel = 2'b01; e.tsz = r0_tsz_i; e.gran = r0_gran_i; e.base = r0_base_i;
    end else if (pick == 1 && !r1_dis_i) begin
      e.sel = 2'b10; e.tsz = r1_tsz_i; e.gran = r1_gran_i; e.base = r1_base_i;
    end else e.fault = 1'b1;
    return e;
  endfunction

  task automatic send(logic [63:0] a, string tag);
    @(negedge clk_i);
    addr_i    = a;
    req_vld_i = 1'b1;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_vld_i = 1'b0;
  endtask

  task automatic cfg(logic [5:0] t0, logic [5:0] t1, bit b0, bit b1, bit d0, bit d1);
    r0_tsz_i = t0; r1_tsz_i = t1; tbi0_i = b0; tbi1_i = b1; r0_dis_i = d0; r1_dis_i = d1;
  endtask

  // monitor: compare each response, and check hold on idle cycles
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      if (rsp_vld_o) begin
        exp_t e; exp_t got; string t;
        got = {sel_o, fault_o, tsz_o, gran_o, base_o};
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected response got %h expected none", got);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL %s got %h expected %h", t, got, e);
          end
          last = e; have_last = 1;
        end
      end else if (have_last) begin
        checks++;
        if ({sel_o, fault_o, tsz_o, gran_o, base_o} !== last) begin
          errors++;
          $display("FAIL R11 idle got %h expected %h",
                   {sel_o, fault_o, tsz_o, gran_o, base_o}, last);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr = 64'h9e37_79b9_7f4a_7c15;
    repeat (3) @(negedge clk_i);
    checks++;
    if ({rsp_vld_o, sel_o, fault_o, tsz_o, gran_o, base_o} !== '0) begin
      errors++;
      $display("FAIL R12 reset got %h expected 0", {rsp_vld_o, sel_o, fault_o, base_o});
    end
    rst_ni = 1'b1;
    r0_gran_i = 2'd1; r0_base_i = 48'h0000_1000_0000;
    r1_gran_i = 2'd2; r1_base_i = 48'h0000_2000_0000;

    cfg(16, 16, 0, 0, 0, 0);
    send(64'h0000_1234_5678_9000, "R3 R10 low region");
    send(64'hFFFF_8000_0000_0000, "R4 R10 high region");
    send(64'h0001_0000_0000_0000, "R7 gap");
    send(64'hFFFE_FFFF_FFFF_FFFF, "R7 gap high");
    cfg(16, 16, 1, 0, 0, 0);
    send(64'hAB00_0000_1234_0000, "R2 ignored byte low");
    send(64'hAB00_FFFF_0000_0000, "R1 bit55 clear uses flag0");
    cfg(16, 16, 0, 1, 0, 0);
    send(64'hAB00_0000_1234_0000, "R1 flag0 off so fault");
    send(64'h12FF_FFFF_0000_0000, "R1 R2 bit55 set uses flag1");
    cfg(8, 4, 1, 1, 0, 0);
    send(64'hFF00_0000_0000_0000, "R2 empty range matches");
    cfg(0, 16, 0, 0, 0, 0);
    send(64'h1234_0000_0000_0000, "R5 zero-size low default");
    send(64'hFFFF_0000_0000_0000, "R4 beats low default");
    cfg(16, 0, 0, 0, 0, 0);
    send(64'h8000_0000_0000_0000, "R6 zero-size high default");
    send(64'h0000_0000_0000_0040, "R3 before high default");
    cfg(0, 0, 0, 0, 0, 0);
    send(64'hDEAD_BEEF_0000_0000, "R5 both zero");
    cfg(16, 16, 0, 0, 1, 0);
    send(64'h0000_0000_0000_1000, "R8 low disabled");
    send(64'hFFFF_0000_0000_1000, "R8 other region ok");
    cfg(16, 16, 0, 0, 0, 1);
    send(64'hFFFF_0000_0000_1000, "R8 high disabled");
    cfg(63, 63, 0, 0, 0, 0);
    send(64'h0000_0000_0000_0001, "R3 largest size");
    send(64'h0000_0000_0000_0002, "R7 largest size gap");
    send(64'hFFFF_FFFF_FFFF_FFFE, "R4 largest size");
    // back-to-back requests
    cfg(20, 12, 1, 0, 0, 0);
    @(negedge clk_i);
    for (int k = 0; k < 4; k++) begin
      addr_i = (k[0]) ? 64'hFFF0_0000_0000_0000 : 64'h0000_0000_0000_0100;
      req_vld_i = 1'b1;
      exp_q.push_back(model(addr_i));
      tag_q.push_back("R9 back-to-back");
      @(negedge clk_i);
    end
    req_vld_i = 1'b0;
    // pseudo-random sweep
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      cfg(lfsr[5:0] & {6{lfsr[40]}}, lfsr[11:6] & {6{lfsr[41]}}, lfsr[12], lfsr[13],
          lfsr[14] & lfsr[15], lfsr[16] & lfsr[17]);
      r0_base_i = lfsr[63:16]; r1_base_i = ~lfsr[63:16];
      send(lfsr[18] ? {{16{lfsr[19]}}, lfsr[47:0]} : {lfsr[63:20], lfsr[19:0]},
           "R3 R4 R5 R6 R7 sweep");
    end
    repeat (4) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule